// File: doc/BRIEF.md
# Saturating Programmable Clock Divider Bank

This block derives three divided clocks from a single root clock: a fast bus clock, a peripheral clock and an auxiliary clock. One 32-bit control word holds the three divide ratios. Software can write or read it at any time through a plain write-strobe and read-data interface. Each divided clock is produced as a registered level signal in the root domain. It is high for the first half of its period, rounded down, and low for the rest.

Every ratio field is cleaned before it reaches its divider: a zero acts as one, and anything above 32 acts as 32. A newly written ratio is held pending and only takes over when the period already running ends. An output therefore never shows a shortened high or low phase. Readback returns the raw field values as written, with the undefined bits forced to zero.

Top module: `clkdiv_bank`

## Requirements
- R1: After reset the control word reads 0x00100404, which makes the bus and peripheral clocks divide by 4 (high 2 of 4 cycles) and the auxiliary clock divide by 16 (high 8 of 16 cycles).
- R2: The bus ratio sits in bits [5:0], the peripheral ratio in bits [13:8] and the auxiliary ratio in bits [23:16]. A write stores the word masked with 0x00FF3F3F, and readback returns exactly that value, so the undefined bits read 0.
- R3: For an even ratio N from 2 to 32, the output repeats every N root cycles and is high for the first N/2 cycles of each period.
- R4: A ratio field of 0 divides by one: the output stays high continuously.
- R5: A ratio field of 1 divides by one: the output stays high continuously.
- R6: A ratio field above 32 behaves exactly like 32 (period 32, high 16).
- R7: A ratio written while a period is in progress leaves that period at the old length and duty. The new ratio governs the period that follows.
- R8: For an odd ratio N, the period is N root cycles and the output is high for floor(N/2) of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Root clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the control word |
| wrData | input | 32 | Control word to write |
| rdData | output | 32 | Stored control word, undefined bits zero |
| hsClk | output | 1 | Divided bus clock |
| perClk | output | 1 | Divided peripheral clock |
| auxClk | output | 1 | Divided auxiliary clock |

## Verification
The dividers are measured from rise to rise with several ratio sets. The reset ratios 4/4/16 are used first. Next comes an even set 8/2/2, and then a set of different odd and even values per field (5/3/6), which catches swapped field positions and off-by-one duty in odd periods. Oversized fields (37, 171) and the 0 and 1 values show the saturation at both ends. A write landing one cycle into a period shows whether the running period finishes at its old length or is cut short.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int MAX_DIV = 32;
  localparam int RATIO_W = $clog2(MAX_DIV + 1);
  localparam int NUM_CH = 3;
  localparam logic [31:0] REG_MASK = 32'h00FF_3F3F;
  localparam logic [31:0] RESET_WORD = 32'h0010_0404;

  typedef logic [RATIO_W-1:0] ratio_t;

  typedef struct packed {
    logic   load;
    ratio_t ratio;
  } chanCmd_t;

  // Raw field of channel idx, zero-extended to 8 bits
  function automatic logic [7:0] rawField(logic [31:0] word, int idx);
    case (idx)
      0:       return {2'b00, word[5:0]};
      1:       return {2'b00, word[13:8]};
      default: return word[23:16];
    endcase
  endfunction

  // Zero acts as one, large values clamp to MAX_DIV
  function automatic ratio_t sanitize(logic [7:0] raw);
    if (raw == 8'd0) return ratio_t'(1);
    if (raw > 8'(MAX_DIV)) return ratio_t'(MAX_DIV);
    return raw[RATIO_W-1:0];
  endfunction
endpackage

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [31:0]            wrData,
  output logic [31:0]            rdData,
  output chanCmd_t [NUM_CH-1:0]  cmds
);
  logic [31:0] regQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regQ <= RESET_WORD;
    else if (wrEn) regQ <= wrData & REG_MASK;
  end

  assign rdData = regQ;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_cmd
    assign cmds[i].load  = wrEn;
    assign cmds[i].ratio = sanitize(rawField(wrData, i));
  end

  // R2
  readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> rdData == ($past(wrData) & REG_MASK));
endmodule

// File: rtl/clkdiv_chan.sv
module clkdiv_chan
  import clkdiv_pkg::*;
#(
  parameter int RESET_DIV = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  chanCmd_t cmd,
  output logic     divOut
);
  localparam ratio_t RST_RATIO = ratio_t'(RESET_DIV);
  localparam logic RST_OUT = (RESET_DIV == 1) || (RESET_DIV / 2 > 0);

  ratio_t activeQ, pendQ, cntQ;
  ratio_t nextPend, nextActive, nextCnt;
  logic boundary, outQ, nextOut;

  assign boundary   = (cntQ == activeQ - ratio_t'(1));
  assign nextPend   = cmd.load ? cmd.ratio : pendQ;
  assign nextActive = boundary ? nextPend : activeQ;
  assign nextCnt    = boundary ? '0 : cntQ + ratio_t'(1);
  assign nextOut    = (nextActive == ratio_t'(1)) || (nextCnt < (nextActive >> 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= RST_RATIO;
      pendQ   <= RST_RATIO;
      cntQ    <= '0;
      outQ    <= RST_OUT;
    end else begin
      activeQ <= nextActive;
      pendQ   <= nextPend;
      cntQ    <= nextCnt;
      outQ    <= nextOut;
    end
  end

  assign divOut = outQ;

  // R6
  ratio_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    activeQ >= ratio_t'(1) && activeQ <= ratio_t'(MAX_DIV));
  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntQ < activeQ);
  // R3
  duty_chk: assert property (@(posedge clk) disable iff (!rstN)
    outQ == ((activeQ == ratio_t'(1)) || (cntQ < (activeQ >> 1))));
  // R7
  ratio_switch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (activeQ != $past(activeQ)) |-> ($past(cntQ) == $past(activeQ) - ratio_t'(1)));
  // R7
  pend_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |=> pendQ == $past(cmd.ratio));
  // R4
  unity_chk: assert property (@(posedge clk) disable iff (!rstN)
    (activeQ == ratio_t'(1)) |-> outQ);
endmodule

// File: rtl/clkdiv_datapath.sv
module clkdiv_datapath
  import clkdiv_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  chanCmd_t [NUM_CH-1:0] cmds,
  output logic [NUM_CH-1:0]     divClk
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int RDIV = int'(sanitize(rawField(RESET_WORD, i)));
    clkdiv_chan #(.RESET_DIV(RDIV)) u_chan (
      .clk    (clk),
      .rstN   (rstN),
      .cmd    (cmds[i]),
      .divOut (divClk[i])
    );
  end
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import clkdiv_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        hsClk,
  output logic        perClk,
  output logic        auxClk
);
  chanCmd_t [NUM_CH-1:0] cmds;
  logic [NUM_CH-1:0] divClk;

  clkdiv_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrData (wrData),
    .rdData (rdData),
    .cmds   (cmds)
  );

  clkdiv_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .cmds   (cmds),
    .divClk (divClk)
  );

  assign hsClk  = divClk[0];
  assign perClk = divClk[1];
  assign auxClk = divClk[2];
endmodule

// File: tb/tb_clkdiv_bank.sv
module tb_clkdiv_bank;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic hsClk, perClk, auxClk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  clkdiv_bank dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .hsClk(hsClk), .perClk(perClk), .auxClk(auxClk)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic getOut(int idx);
    case (idx)
      0:       return hsClk;
      1:       return perClk;
      default: return auxClk;
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", req, what, act, act, exp, exp);
    end
  endtask

  task automatic writeWord(logic [31:0] w);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = w;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Sync to a rising output, then count high and total cycles of one period
  task automatic measure(int idx, int expH, int expN, string req);
    int h = 0, l = 0, guard = 0;
    @(negedge clk);
    while (getOut(idx) !== 1'b0 && guard < 200) begin @(negedge clk); guard++; end
    while (getOut(idx) !== 1'b1 && guard < 200) begin @(negedge clk); guard++; end
    while (getOut(idx) === 1'b1 && guard < 200) begin h++; @(negedge clk); guard++; end
    while (getOut(idx) === 1'b0 && guard < 200) begin l++; @(negedge clk); guard++; end
    check(h == expH, req, $sformatf("ch%0d high cycles", idx), h, expH);
    check(h + l == expN, req, $sformatf("ch%0d period", idx), h + l, expN);
  endtask

  task automatic expectConstHigh(int idx, string req);
    int lows = 0;
    repeat (40) @(negedge clk);
    for (int k = 0; k < 12; k++) begin
      if (getOut(idx) !== 1'b1) lows++;
      @(negedge clk);
    end
    check(lows == 0, req, $sformatf("ch%0d low samples at divide by one", idx), lows, 0);
  endtask

  task automatic testReset();
    check(rdData == 32'h0010_0404, "R1", "reset readback", rdData, 32'h0010_0404);
    measure(0, 2, 4, "R1");
    measure(1, 2, 4, "R1");
    measure(2, 8, 16, "R1");
  endtask

  task automatic testMaskAndClamp();
    writeWord(32'hFFFF_FFFF);
    check(rdData == 32'h00FF_3F3F, "R2", "masked readback", rdData, 32'h00FF_3F3F);
    writeWord(32'h00AB_1525);
    check(rdData == 32'h00AB_1525, "R2", "raw readback", rdData, 32'h00AB_1525);
    measure(0, 16, 32, "R6");
    measure(1, 10, 21, "R8");
    measure(2, 16, 32, "R6");
  endtask

  task automatic testZeroOne();
    writeWord(32'h0000_0100);
    expectConstHigh(0, "R4");
    expectConstHigh(1, "R5");
    expectConstHigh(2, "R4");
  endtask

  task automatic testEvenSet();
    writeWord(32'h0002_0208);
    measure(0, 4, 8, "R3");
    measure(1, 1, 2, "R3");
    measure(2, 1, 2, "R3");
  endtask

  task automatic testMixedFields();
    writeWord(32'h0006_0305);
    measure(0, 2, 5, "R8");
    measure(1, 1, 3, "R8");
    measure(2, 3, 6, "R3");
  endtask

  // Write lands one cycle into a period; that period must keep the old shape
  task automatic testGlitchFree(int idx, int oldH, int oldN, logic [31:0] newWord, int newH, int newN);
    int h = 0, l = 0, guard = 0;
    writeWord(32'h0010_0404);
    measure(idx, oldH, oldN, "R7");
    @(negedge clk);
    while (getOut(idx) !== 1'b0 && guard < 200) begin @(negedge clk); guard++; end
    while (getOut(idx) !== 1'b1 && guard < 200) begin @(negedge clk); guard++; end
    h = 1;
    wrEn = 1'b1;
    wrData = newWord;
    @(negedge clk);
    wrEn = 1'b0;
    while (getOut(idx) === 1'b1 && guard < 200) begin h++; @(negedge clk); guard++; end
    while (getOut(idx) === 1'b0 && guard < 200) begin l++; @(negedge clk); guard++; end
    check(h == oldH, "R7", $sformatf("ch%0d high of interrupted period", idx), h, oldH);
    check(h + l == oldN, "R7", $sformatf("ch%0d length of interrupted period", idx), h + l, oldN);
    measure(idx, newH, newN, "R7");
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testMaskAndClamp();
    testZeroOne();
    testEvenSet();
    testMixedFields();
    testGlitchFree(0, 2, 4, 32'h0010_0403, 1, 3);
    testGlitchFree(2, 8, 16, 32'h0004_0404, 2, 4);
    finish();
  end
endmodule